// File: doc/BRIEF.md
# Preemptive DMA Channel Priority Arbiter

This block decides which of a set of DMA channels (eight by default) owns the transfer engine. Each channel can be asked for service in two ways. Software can set an internal request. An interrupt line can raise an external request, and a per-channel mode bit chooses how that line is captured. In edge mode a rising edge is caught and kept. In level mode the line counts only while it stays high. The lowest-numbered channel with a pending request always wins.

The grant may move only while the engine is idle, or on the cycle in which the engine strobes the end of a transfer unit, meaning its holding register has been written out completely. A higher-priority request that arrives during a transfer therefore takes over at the next unit boundary. The channel it displaced keeps its pending request and regains the grant once every higher channel has been cleared. The engine removes a channel's latched requests, internal and edge-captured, with a per-channel clear strobe.

The only data-like output is the grant, and the engine always accepts it. For that reason there is no ready/back-pressure path: the grant is a registered one-hot vector with a valid flag, and every other pin is a plain control level or strobe.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, `grant` is all zeros and `grant_valid` is 0.
- R2: When the grant is updated, the granted bit is the lowest-indexed channel with a pending request, so channel 0 beats channel 1 when both ask at once.
- R3: While `grant_valid` is 1 and `xfer_done` is 0, `grant` does not change, even if a higher-priority request arrives.
- R4: A higher-priority request that arrives while a lower channel is granted takes the grant in the cycle after the next `xfer_done`.
- R5: A preempted lower channel whose request is still pending gets the grant back at the first `xfer_done` after all higher requests have been cleared.
- R6: A one-cycle pulse on `int_req[i]` keeps channel i pending across any number of transfer boundaries until `req_clr[i]` is pulsed.
- R7: With `ext_edge_mode[i]`=1, a 0-to-1 transition of `ext_req[i]` keeps channel i pending after the line falls again, until `req_clr[i]` is pulsed.
- R8: With `ext_edge_mode[i]`=0, channel i is pending only while `ext_req[i]` is 1. If the line drops before a boundary, the channel is not granted at that boundary.
- R9: A request whose set pulse arrives in the same cycle as `xfer_done` takes part in that cycle's arbitration.
- R10: If no channel is pending at an update point, `grant_valid` becomes 0 and `grant` all zeros. `grant` is always one-hot or zero, and `grant_valid` is 1 exactly when `grant` is nonzero.
- R11: When a set (`int_req`) and a clear (`req_clr`) hit the same channel in the same cycle, the set wins. A clear in the same cycle as `xfer_done` removes that channel from that cycle's arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_req | input | NCH | Per-channel internal request set pulse |
| ext_req | input | NCH | Per-channel external request line |
| ext_edge_mode | input | NCH | 1: capture rising edges of ext_req; 0: level |
| xfer_done | input | 1 | Engine strobe: current transfer unit fully written |
| req_clr | input | NCH | Per-channel clear of latched requests |
| grant | output | NCH | One-hot granted channel, bit i = channel i |
| grant_valid | output | 1 | A channel is granted |

## Verification
Every result is due one clock edge after the stimulus. Inputs sampled at edge k, including `xfer_done`, request pulses and clears, show up on `grant` and `grant_valid` just after edge k, because the only registers on the path are the grant flops and the request latches that feed the same cycle's decision. The bench drives each stimulus on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Pulse inputs are removed at that same falling edge. For hold checks (R3) the bench repeats this one-edge step with no `xfer_done`, and it confirms the grant unchanged after each edge.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  parameter int unsigned DEF_NCH = 8;
endpackage

// File: rtl/dma_req_capture.sv
module dma_req_capture #(
  parameter int unsigned NCH = dma_arb_pkg::DEF_NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] int_req,
  input  logic [NCH-1:0] ext_req,
  input  logic [NCH-1:0] ext_edge_mode,
  input  logic [NCH-1:0] req_clr,
  output logic [NCH-1:0] req_now
);
  logic [NCH-1:0] int_pend, edge_pend, ext_q;
  logic [NCH-1:0] int_next, edge_next, rise;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // set wins over clear in the same cycle
    assign rise[i]      = ext_req[i] & ~ext_q[i] & ext_edge_mode[i];
    assign int_next[i]  = (int_pend[i] & ~req_clr[i]) | int_req[i];
    assign edge_next[i] = (edge_pend[i] & ~req_clr[i]) | rise[i];
    // current-cycle view: includes pulses arriving now
    assign req_now[i]   = int_next[i] |
                          (ext_edge_mode[i] ? edge_next[i] : ext_req[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_pend  <= '0;
      edge_pend <= '0;
      ext_q     <= '0;
    end else begin
      int_pend  <= int_next;
      edge_pend <= edge_next & ext_edge_mode;
      ext_q     <= ext_req;
    end
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int unsigned NCH = dma_arb_pkg::DEF_NCH
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] pick,
  output logic           any
);
  // isolate lowest set bit: lower index = higher priority
  assign pick = req & (~req + {{(NCH-1){1'b0}}, 1'b1});
  assign any  = |req;
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int unsigned NCH = dma_arb_pkg::DEF_NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] int_req,
  input  logic [NCH-1:0] ext_req,
  input  logic [NCH-1:0] ext_edge_mode,
  input  logic           xfer_done,
  input  logic [NCH-1:0] req_clr,
  output logic [NCH-1:0] grant,
  output logic           grant_valid
);
  logic [NCH-1:0] req_now, pick;
  logic           any;
  logic           update;

  dma_req_capture #(.NCH(NCH)) u_cap (
    .clk(clk), .rst_n(rst_n), .int_req(int_req), .ext_req(ext_req),
    .ext_edge_mode(ext_edge_mode), .req_clr(req_clr), .req_now(req_now)
  );

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .req(req_now), .pick(pick), .any(any)
  );

  // grant moves only when idle or at a transfer-unit boundary
  assign update = !grant_valid || xfer_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant       <= '0;
      grant_valid <= 1'b0;
    end else if (update) begin
      grant       <= pick;
      grant_valid <= any;
    end
  end
endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk #(
  parameter int unsigned NCH = dma_arb_pkg::DEF_NCH
) (
  input logic           clk,
  input logic           rst_n,
  input logic           xfer_done,
  input logic [NCH-1:0] req_now,
  input logic [NCH-1:0] grant,
  input logic           grant_valid
);
  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_valid_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant != '0));

  assert_hold_midunit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !xfer_done) |=> $stable(grant));

  assert_granted_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid || xfer_done) |=> ((grant & $past(req_now)) == grant));

  assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid || xfer_done) |=>
      (((grant - {{(NCH-1){1'b0}}, 1'b1}) & $past(req_now)) == '0));

  assert_idle_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((!grant_valid || xfer_done) && req_now == '0) |=> !grant_valid);
endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .req_now(req_now),
  .grant(grant), .grant_valid(grant_valid)
);

// File: tb/dma_prio_arbiter_test.sv
`timescale 1ns/1ps
module dma_prio_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] int_req = '0, ext_req = '0, ext_edge_mode = '0, req_clr = '0;
  logic       xfer_done = 1'b0;
  logic [7:0] grant;
  logic       grant_valid;
  int         n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dma_prio_arbiter #(.NCH(8)) uut (
    .clk(clk), .rst_n(rst_n), .int_req(int_req), .ext_req(ext_req),
    .ext_edge_mode(ext_edge_mode), .xfer_done(xfer_done), .req_clr(req_clr),
    .grant(grant), .grant_valid(grant_valid)
  );

  task automatic check(input string tag, input logic [7:0] eg, input logic ev);
    n_checks++;
    if (grant !== eg || grant_valid !== ev) begin
      n_fail++;
      $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
               tag, grant, grant_valid, eg, ev);
    end
  endtask

  // drive pulses at a falling edge, pass one rising edge, remove pulses
  task automatic step(input logic [7:0] i, input logic [7:0] c, input logic d);
    int_req = i; req_clr = c; xfer_done = d;
    @(negedge clk);
    int_req = '0; req_clr = '0; xfer_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; int_req = '0; ext_req = '0; ext_edge_mode = '0;
    req_clr = '0; xfer_done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset state", 8'h00, 1'b0);
  endtask

  task automatic t_priority();
    do_reset();
    step(8'h03, 8'h00, 1'b0); check("R2 ch0 beats ch1", 8'h01, 1'b1);
    step(8'hA0, 8'h00, 1'b0); check("R3 hold without done", 8'h01, 1'b1);
    step(8'h00, 8'h01, 1'b1); check("R6 ch1 still pending", 8'h02, 1'b1);
    step(8'h00, 8'h02, 1'b1); check("R2 ch5 next", 8'h20, 1'b1);
    step(8'h00, 8'h20, 1'b1); check("R6 ch7 held", 8'h80, 1'b1);
    step(8'h00, 8'h80, 1'b1); check("R10 idle", 8'h00, 1'b0);
  endtask

  task automatic t_preempt();
    do_reset();
    step(8'h20, 8'h00, 1'b0); check("R2 ch5 alone", 8'h20, 1'b1);
    step(8'h04, 8'h00, 1'b0); check("R3 no switch mid-unit", 8'h20, 1'b1);
    step(8'h00, 8'h00, 1'b0); check("R3 still held", 8'h20, 1'b1);
    step(8'h00, 8'h00, 1'b1); check("R4 preempt at boundary", 8'h04, 1'b1);
    step(8'h00, 8'h04, 1'b1); check("R5 resume ch5", 8'h20, 1'b1);
    step(8'h00, 8'h20, 1'b1); check("R10 idle after", 8'h00, 1'b0);
  endtask

  task automatic t_edge();
    do_reset();
    ext_edge_mode = 8'h08; ext_req = 8'h08;
    step(8'h00, 8'h00, 1'b0); check("R7 edge captured", 8'h08, 1'b1);
    ext_req = 8'h00;
    step(8'h00, 8'h00, 1'b1); check("R7 latched after drop", 8'h08, 1'b1);
    step(8'h00, 8'h08, 1'b1); check("R7 cleared", 8'h00, 1'b0);
  endtask

  task automatic t_level();
    do_reset();
    ext_edge_mode = 8'h00; ext_req = 8'h10;
    step(8'h40, 8'h00, 1'b0); check("R8 level high wins", 8'h10, 1'b1);
    ext_req = 8'h00;
    step(8'h00, 8'h00, 1'b1); check("R8 dropped not held", 8'h40, 1'b1);
    step(8'h00, 8'h40, 1'b1); check("R8 idle", 8'h00, 1'b0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    step(8'h80, 8'h00, 1'b0); check("R9 ch7 granted", 8'h80, 1'b1);
    step(8'h02, 8'h80, 1'b1); check("R9 arrival with done", 8'h02, 1'b1);
    step(8'h00, 8'h02, 1'b1); check("R11 clear with done", 8'h00, 1'b0);
    step(8'h01, 8'h01, 1'b0); check("R11 set beats clear", 8'h01, 1'b1);
    step(8'h00, 8'h01, 1'b1); check("R11 cleared", 8'h00, 1'b0);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_preempt();
    t_edge();
    t_level();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule